// File: doc/BRIEF.md
# Snooping Load Queue Violation Detector

This block keeps track of the loads a core has allocated but not yet committed. A load takes a slot at the tail in program order. Once its address is known it is marked issued, and it leaves from the head in order. Invalidations from other processors or I/O agents, and line evictions from an inclusive cache, are both turned into searches of the queue. A search compares its line address with every issued load.

When a search hits, the block names the oldest matching load so that replay logic can re-execute from that point. That load and every younger load are dropped in the same cycle, and the allocation pointer rewinds to the squashed slot. Only one search is served per cycle. When an invalidation and an eviction collide, the eviction waits in a one-entry hold register and is served in the next cycle.

Top module: `snoop_load_queue`

## Requirements
- R1: `alloc_req` is accepted (`alloc_ack`=1) into slot `alloc_idx`, and slots are handed out in rising index order with wraparound. A request is refused in any cycle where `full` or `squash_vld` is high.
- R2: `issue_vld` marks slot `issue_idx` as issued and captures `issue_addr`, but only if that slot is valid and not yet issued. In every other case the issue is ignored, and a later search for the new address finds nothing.
- R3: `retire_req` frees the head slot only when that slot is valid and issued, and `retire_ack` is 1 in that cycle. After a retire, `full` is 0 in the next cycle.
- R4: An invalidation (`inv_vld`) is compared against every issued, valid slot using address bits [31:6] only; bits [5:0] are ignored. Slots that are not issued never match.
- R5: An eviction (`evict_vld`) performs the same search as an invalidation. `squash_src` reports the source of the served search: 0 for an invalidation, 1 for an eviction.
- R6: When the served search matches one or more slots, `squash_vld` goes to 1 in the same cycle, and `squash_idx` names the matching slot that is oldest counting from the head.
- R7: On a squash, the named slot and all younger slots become invalid, and in the next cycle `alloc_idx` equals the squashed slot index.
- R8: When an invalidation and an eviction arrive together, the invalidation is served. The eviction is held, `snoop_stall` is 1 for exactly the next cycle, and the held eviction is served in that cycle. Sources present no new search while `snoop_stall` is 1.
- R9: A head slot retired in the same cycle as a matching search is treated as committed. It is not reported, and the next-oldest match is reported instead.
- R10: `full` is 1 exactly when every slot holds a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a new load slot |
| alloc_ack | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation takes (tail) |
| full | output | 1 | All slots occupied |
| issue_vld | input | 1 | Load address becomes known |
| issue_idx | input | log2(DEPTH) | Slot being issued |
| issue_addr | input | 32 | Byte address of the issued load |
| retire_req | input | 1 | Commit the head load |
| retire_ack | output | 1 | Head load committed this cycle |
| inv_vld | input | 1 | External invalidation present |
| inv_addr | input | 32 | Invalidated byte address |
| evict_vld | input | 1 | Inclusive-cache eviction present |
| evict_addr | input | 32 | Evicted byte address |
| snoop_stall | output | 1 | Held eviction being served; no new search allowed |
| squash_vld | output | 1 | Served search hit an issued load |
| squash_idx | output | log2(DEPTH) | Oldest matching slot |
| squash_src | output | 1 | 0 = invalidation, 1 = eviction |

## Verification
A directed pass on an eight-slot queue first fills the queue and then issues only some slots. Several slots are given the same line, so the tests can tell an unissued-slot match from an issued one, the oldest match from any other match, a duplicate issue from a real one, and the head-retire exemption from an ordinary head hit. One cycle carries both an invalidation and an eviction, which separates the served source from the held one. A long pseudo-random sweep follows. It draws searches from a small pool of lines, including one that differs only in the top address bit, with random low offsets, so that errors in line slicing and offset masking show up. Every cycle is compared against an arithmetic model of head, tail, valid and issued state.

// File: rtl/slq_pkg.sv
package slq_pkg;
    localparam int ADDR_W   = 32;
    localparam int LINE_LSB = 6;
    localparam int LINE_W   = ADDR_W - LINE_LSB;

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {
        SRC_INV   = 1'b0,
        SRC_EVICT = 1'b1
    } snoop_src_e;

    typedef struct packed {
        logic       vld;
        line_t      line;
        snoop_src_e src;
    } snoop_req_t;

    function automatic line_t line_of(input logic [ADDR_W-1:0] addr);
        return addr[ADDR_W-1:LINE_LSB];
    endfunction
endpackage

// File: rtl/slq_arbiter.sv
module slq_arbiter
    import slq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_vld,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              evict_vld,
    input  logic [ADDR_W-1:0] evict_addr,
    output snoop_req_t        served,
    output logic              stall
);
    snoop_req_t hold_q;

    // Held eviction first, then invalidation, then eviction.
    always_comb begin
        served = '0;
        if (hold_q.vld)
            served = hold_q;
        else if (inv_vld)
            served = '{vld: 1'b1, line: line_of(inv_addr), src: SRC_INV};
        else if (evict_vld)
            served = '{vld: 1'b1, line: line_of(evict_addr), src: SRC_EVICT};
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (!hold_q.vld && inv_vld && evict_vld)
            hold_q <= '{vld: 1'b1, line: line_of(evict_addr), src: SRC_EVICT};
        else
            hold_q <= '0;
    end

    assign stall = hold_q.vld;
endmodule

// File: rtl/slq_entry.sv
module slq_entry
    import slq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       alloc_we,
    input  logic       issue_we,
    input  line_t      issue_line,
    input  logic       clr,
    input  snoop_req_t srch,
    output logic       vld,
    output logic       iss,
    output logic       hit
);
    line_t line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            iss <= 1'b0;
        end else if (clr) begin
            vld <= 1'b0;
            iss <= 1'b0;
        end else if (alloc_we) begin
            vld <= 1'b1;
            iss <= 1'b0;
        end else if (issue_we) begin
            iss <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (issue_we)
            line_q <= issue_line;
    end

    assign hit = srch.vld && vld && iss && (line_q == srch.line);
endmodule

// File: rtl/slq_oldest.sv
module slq_oldest #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] match,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from youngest age to oldest so the smallest age wins last.
    always_comb begin
        found = 1'b0;
        idx   = head;
        for (int a = DEPTH - 1; a >= 0; a--) begin
            logic [IDX_W-1:0] j;
            j = head + IDX_W'(a);
            if (match[j]) begin
                found = 1'b1;
                idx   = j;
            end
        end
    end
endmodule

// File: rtl/snoop_load_queue.sv
module snoop_load_queue
    import slq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic              alloc_ack,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    input  logic              issue_vld,
    input  logic [IDX_W-1:0]  issue_idx,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              retire_req,
    output logic              retire_ack,
    input  logic              inv_vld,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              evict_vld,
    input  logic [ADDR_W-1:0] evict_addr,
    output logic              snoop_stall,
    output logic              squash_vld,
    output logic [IDX_W-1:0]  squash_idx,
    output logic              squash_src
);
    logic [IDX_W-1:0] head_q, tail_q;
    logic [DEPTH-1:0] ent_vld, ent_iss, ent_hit, head_mask, match;
    logic [IDX_W-1:0] sq_age;
    logic             sq_found;
    logic [IDX_W-1:0] sq_idx;
    snoop_req_t       served;

    slq_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .inv_vld    (inv_vld),
        .inv_addr   (inv_addr),
        .evict_vld  (evict_vld),
        .evict_addr (evict_addr),
        .served     (served),
        .stall      (snoop_stall)
    );

    assign retire_ack = retire_req && ent_vld[head_q] && ent_iss[head_q];
    assign head_mask  = retire_ack ? (DEPTH'(1) << head_q) : '0;
    assign match      = ent_hit & ~head_mask;

    slq_oldest #(.DEPTH(DEPTH)) u_pick (
        .match (match),
        .head  (head_q),
        .found (sq_found),
        .idx   (sq_idx)
    );

    assign sq_age     = sq_idx - head_q;
    assign full       = ent_vld[tail_q];
    assign alloc_ack  = alloc_req && !full && !sq_found;
    assign alloc_idx  = tail_q;
    assign squash_vld = sq_found;
    assign squash_idx = sq_idx;
    assign squash_src = served.src;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [IDX_W-1:0] age;
        logic             kill;
        assign age  = IDX_W'(i) - head_q;
        assign kill = sq_found && (age >= sq_age);

        slq_entry u_ent (
            .clk        (clk),
            .rst        (rst),
            .alloc_we   (alloc_ack && (tail_q == IDX_W'(i))),
            .issue_we   (issue_vld && (issue_idx == IDX_W'(i)) && ent_vld[i] && !ent_iss[i]),
            .issue_line (line_of(issue_addr)),
            .clr        (kill || (retire_ack && (head_q == IDX_W'(i)))),
            .srch       (served),
            .vld        (ent_vld[i]),
            .iss        (ent_iss[i]),
            .hit        (ent_hit[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (retire_ack)
                head_q <= head_q + 1'b1;
            if (sq_found)
                tail_q <= sq_idx;
            else if (alloc_ack)
                tail_q <= tail_q + 1'b1;
        end
    end
endmodule

// File: rtl/slq_checker.sv
module slq_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_ack,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             full,
    input logic             retire_ack,
    input logic             inv_vld,
    input logic             evict_vld,
    input logic             snoop_stall,
    input logic             squash_vld,
    input logic [IDX_W-1:0] squash_idx
);
    // R10
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_ack);

    // R1
    squash_blocks_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        squash_vld |-> !alloc_ack);

    // R1
    alloc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_ack |=> (alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)));

    // R7
    squash_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        squash_vld |=> (alloc_idx == $past(squash_idx)));

    // R3
    retire_frees_chk: assert property (@(posedge clk) disable iff (rst)
        retire_ack |=> !full);

    // R8
    hold_set_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_vld && evict_vld && !snoop_stall) |=> snoop_stall);

    // R8
    hold_once_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_stall |=> !snoop_stall);
endmodule

bind snoop_load_queue slq_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_ack   (alloc_ack),
    .alloc_idx   (alloc_idx),
    .full        (full),
    .retire_ack  (retire_ack),
    .inv_vld     (inv_vld),
    .evict_vld   (evict_vld),
    .snoop_stall (snoop_stall),
    .squash_vld  (squash_vld),
    .squash_idx  (squash_idx)
);

// File: tb/snoop_load_queue_test.sv
module snoop_load_queue_test;
    import slq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int D  = 8;
    localparam int IW = $clog2(D);

    logic clk = 1'b0;
    logic rst;
    logic alloc_req, issue_vld, retire_req, inv_vld, evict_vld;
    logic [IW-1:0] issue_idx;
    logic [ADDR_W-1:0] issue_addr, inv_addr, evict_addr;
    logic alloc_ack, full, retire_ack, snoop_stall, squash_vld, squash_src;
    logic [IW-1:0] alloc_idx, squash_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state
    bit    m_v [D];
    bit    m_i [D];
    line_t m_l [D];
    int    m_head, m_tail;
    bit    h_v;
    line_t h_l;
    // Expected values of the current cycle
    bit e_ret, e_sq, e_full, e_aa;
    int e_sqi;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snoop_load_queue #(.DEPTH(D)) uut (
        .clk(clk), .rst(rst),
        .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_idx(alloc_idx), .full(full),
        .issue_vld(issue_vld), .issue_idx(issue_idx), .issue_addr(issue_addr),
        .retire_req(retire_req), .retire_ack(retire_ack),
        .inv_vld(inv_vld), .inv_addr(inv_addr),
        .evict_vld(evict_vld), .evict_addr(evict_addr),
        .snoop_stall(snoop_stall), .squash_vld(squash_vld),
        .squash_idx(squash_idx), .squash_src(squash_src)
    );

    task automatic chk(input int act, input int exp, input string req);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input line_t l, input int ofs);
        return {l, 6'(ofs)};
    endfunction

    function automatic line_t pool_line(input int k);
        case (k)
            0: return line_t'(5);
            1: return line_t'(9);
            2: return line_t'(5) | (line_t'(1) << (LINE_W - 1));
            default: return line_t'(13);
        endcase
    endfunction

    task automatic idle();
        alloc_req = 0; issue_vld = 0; issue_idx = '0; issue_addr = '0;
        retire_req = 0; inv_vld = 0; inv_addr = '0; evict_vld = 0; evict_addr = '0;
    endtask

    // Compute expected outputs from the reference state and compare.
    task automatic settle();
        bit    s_v;
        line_t s_l;
        int    s_src;
        #1;
        s_v = 0; s_l = '0; s_src = 0;
        if (h_v) begin s_v = 1; s_l = h_l; s_src = 1; end
        else if (inv_vld) begin s_v = 1; s_l = line_of(inv_addr); s_src = 0; end
        else if (evict_vld) begin s_v = 1; s_l = line_of(evict_addr); s_src = 1; end
        e_ret = retire_req && m_v[m_head] && m_i[m_head];
        e_sq = 0; e_sqi = 0;
        for (int a = 0; a < D; a++) begin
            int j = (m_head + a) % D;
            if (!e_sq && s_v && m_v[j] && m_i[j] && m_l[j] == s_l && !(e_ret && j == m_head)) begin
                e_sq = 1; e_sqi = j;
            end
        end
        e_full = m_v[m_tail];
        e_aa = alloc_req && !e_full && !e_sq;
        chk(int'(alloc_ack), int'(e_aa), "R1 alloc_ack");
        chk(int'(alloc_idx), m_tail, "R7 alloc_idx");
        chk(int'(full), int'(e_full), "R10 full");
        chk(int'(retire_ack), int'(e_ret), "R3 retire_ack");
        chk(int'(squash_vld), int'(e_sq), "R6 squash_vld");
        chk(int'(snoop_stall), int'(h_v), "R8 snoop_stall");
        if (e_sq) begin
            chk(int'(squash_idx), e_sqi, "R6 squash_idx");
            chk(int'(squash_src), s_src, "R5 squash_src");
        end
    endtask

    // Clock edge: update the reference state.
    task automatic advance();
        int old_head, sq_age;
        @(posedge clk);
        old_head = m_head;
        if (issue_vld && m_v[issue_idx] && !m_i[issue_idx]) begin
            m_i[issue_idx] = 1;
            m_l[issue_idx] = line_of(issue_addr);
        end
        if (e_ret) begin
            m_v[m_head] = 0; m_i[m_head] = 0;
            m_head = (m_head + 1) % D;
        end
        if (e_sq) begin
            sq_age = (e_sqi - old_head + D) % D;
            for (int a = sq_age; a < D; a++) begin
                m_v[(old_head + a) % D] = 0;
                m_i[(old_head + a) % D] = 0;
            end
            m_tail = e_sqi;
        end else if (e_aa) begin
            m_v[m_tail] = 1; m_i[m_tail] = 0;
            m_tail = (m_tail + 1) % D;
        end
        if (!h_v && inv_vld && evict_vld) begin
            h_v = 1; h_l = line_of(evict_addr);
        end else begin
            h_v = 0;
        end
        @(negedge clk);
    endtask

    task automatic step();
        settle();
        advance();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < D; i++) begin m_v[i] = 0; m_i[i] = 0; m_l[i] = '0; end
        m_head = 0; m_tail = 0; h_v = 0; h_l = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // Reset state
        settle();
        chk(int'(full), 0, "R10 reset");
        chk(int'(alloc_idx), 0, "R1 reset");
        chk(int'(squash_vld), 0, "R6 reset");
        advance();

        // R1, R10: fill in order, then refuse
        alloc_req = 1;
        for (int i = 0; i < D; i++) begin
            settle();
            chk(int'(alloc_idx), i, "R1 order");
            advance();
        end
        settle();
        chk(int'(full), 1, "R10 full");
        chk(int'(alloc_ack), 0, "R10 refused");
        advance();
        idle();

        // R2: issue all slots except 1
        for (int i = 0; i < D; i++) begin
            if (i != 1) begin
                int ln;
                ln = (i == 0 || i == 3 || i == 6) ? 5 : (i == 2 || i == 4) ? 9 : 11 + i;
                issue_vld = 1; issue_idx = IW'(i); issue_addr = mk_addr(line_t'(ln), i * 7);
                step();
            end
        end
        idle();

        // R4: slot 1 holds no address yet, line 7 must not match
        inv_vld = 1; inv_addr = mk_addr(line_t'(7), 63);
        settle();
        chk(int'(squash_vld), 0, "R4 unissued ignored");
        advance();
        idle();

        // R2: re-issue of slot 2 with line 7 is ignored
        issue_vld = 1; issue_idx = 3'd2; issue_addr = mk_addr(line_t'(7), 0);
        step();
        idle();
        inv_vld = 1; inv_addr = mk_addr(line_t'(7), 1);
        settle();
        chk(int'(squash_vld), 0, "R2 duplicate issue ignored");
        advance();
        idle();

        // R9, R6: head 0 retires; line 5 held by 0, 3, 6 -> oldest remaining is 3
        retire_req = 1; inv_vld = 1; inv_addr = mk_addr(line_t'(5), 32);
        settle();
        chk(int'(retire_ack), 1, "R9 retire");
        chk(int'(squash_vld), 1, "R6 hit");
        chk(int'(squash_idx), 3, "R9 head exempt, R6 oldest");
        chk(int'(squash_src), 0, "R5 inv source");
        advance();
        idle();
        settle();
        chk(int'(alloc_idx), 3, "R7 rewind");
        advance();

        // R8, R5: issue slot 1 then collide invalidation (miss) and eviction (hit slot 2)
        issue_vld = 1; issue_idx = 3'd1; issue_addr = mk_addr(line_t'(7), 4);
        step();
        idle();
        inv_vld = 1; inv_addr = mk_addr(line_t'(13), 0);
        evict_vld = 1; evict_addr = mk_addr(line_t'(9), 17);
        settle();
        chk(int'(squash_vld), 0, "R8 invalidation served first");
        advance();
        idle();
        settle();
        chk(int'(snoop_stall), 1, "R8 stall");
        chk(int'(squash_vld), 1, "R8 held eviction served");
        chk(int'(squash_idx), 2, "R5 eviction hit");
        chk(int'(squash_src), 1, "R5 eviction source");
        advance();

        // Pseudo-random sweep against the reference
        for (int c = 0; c < 6000; c++) begin
            idle();
            alloc_req  = ($urandom % 3) != 0;
            issue_vld  = ($urandom % 2) != 0;
            issue_idx  = IW'($urandom % D);
            issue_addr = mk_addr(pool_line($urandom % 4), $urandom % 64);
            retire_req = ($urandom % 3) == 0;
            if (!h_v) begin
                inv_vld    = ($urandom % 5) == 0;
                inv_addr   = mk_addr(pool_line($urandom % 4), $urandom % 64);
                evict_vld  = ($urandom % 5) == 0;
                evict_addr = mk_addr(pool_line($urandom % 4), $urandom % 64);
            end
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule